// File: doc/BRIEF.md
# Reset-Latched Clock Divider Controller

This block fixes a six-bit clock configuration word at the moment the internal power-on reset is released. It then turns one internal reference clock into periodic single-cycle enable strobes for three peripheral domains. Three bits of the word come from dedicated mode pins. The other three come from the high-order field of a reset configuration word. After release the word is frozen, and downstream logic decodes it into one of 64 clock configurations.

Two of the strobe domains divide by fixed factors: the communications-processor domain by 2 and the serial-controller domain by 4. The baud-rate domain divides by a factor chosen through a small control register. That factor is one of 4, 16, 64 or 256, and it comes back to 16 on every reset. Writing the select restarts the baud counter, so a pulse is never early and never clipped.

Top module: `clkdiv_ctrl_top`

## Requirements
- R1: `mode_word` equals `{cfg_hi, mode_pins}` (configuration-word bits in [5:3], pin bits in [2:0]) as sampled on the last rising clock edge at which `por_rst` is high.
- R2: While `por_rst` is low, `mode_word` holds its captured value whatever `mode_pins` and `cfg_hi` do.
- R3: `por_rst` is a synchronous active-high reset. From the first edge with `por_rst` high until one edge after it falls, `scc_en`, `cpm_en` and `baud_en` are all low.
- R4: `cpm_en` is high for exactly one cycle in every 2. It is first high after the 2nd rising edge following reset release.
- R5: `scc_en` is high for exactly one cycle in every 4. It is first high after the 4th rising edge following reset release.
- R6: After reset the baud select is 2'b01, so `baud_en` pulses once every 16 cycles, counted from reset release. A select write made while `por_rst` is high has no effect.
- R7: The 2-bit baud select encodes the divide factor as 00 = 4, 01 = 16, 10 = 64 and 11 = 256. A cycle with `bsel_wr` high loads `bsel_data`.
- R8: Any select write restarts the baud counter. `baud_en` is low on the write edge and first goes high N edges later, where N is the new factor. It then pulses every N cycles.
- R9: Every `scc_en` pulse coincides with a `cpm_en` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal reference clock |
| por_rst | input | 1 | Internal power-on reset, synchronous, active high |
| mode_pins | input | 3 | Dedicated mode pins, low three bits of the mode word |
| cfg_hi | input | 3 | High-order mode field from the reset configuration word |
| bsel_wr | input | 1 | Write strobe for the baud select field |
| bsel_data | input | 2 | New baud select value |
| mode_word | output | 6 | Captured clock configuration mode |
| scc_en | output | 1 | Serial-controller clock enable, 1 in 4 |
| cpm_en | output | 1 | Communications-processor clock enable, 1 in 2 |
| baud_en | output | 1 | Baud-rate clock enable, 1 in N |

## Verification
The assertions take `por_rst` to be a level that is sampled on clock edges. They assume the mode inputs and the write port change only between edges and never carry X once reset has been sampled. The stimulus drives every input on the falling clock edge. It toggles the mode pins and the configuration field freely both inside and outside reset, and it places baud writes both inside a reset window and in the middle of a running baud period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CNT_W   = 8;
    localparam int CPM_DIV = 2;
    localparam int SCC_DIV = 4;
    localparam int N_FIXED = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        BAUD_DIV4   = 2'b00,
        BAUD_DIV16  = 2'b01,
        BAUD_DIV64  = 2'b10,
        BAUD_DIV256 = 2'b11
    } baud_sel_e;

    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] pins;
    } mode_word_t;

    typedef struct packed {
        logic scc;
        logic cpm;
        logic baud;
    } clk_en_t;

    // terminal count (factor minus one) for a baud select code
    function automatic cnt_t baud_last(baud_sel_e s);
        case (s)
            BAUD_DIV4:   return cnt_t'(3);
            BAUD_DIV16:  return cnt_t'(15);
            BAUD_DIV64:  return cnt_t'(63);
            default:     return cnt_t'(255);
        endcase
    endfunction

    function automatic int fixed_div(int idx);
        return (idx == 0) ? CPM_DIV : SCC_DIV;
    endfunction

endpackage

// File: rtl/clkdiv_mode_latch.sv
module clkdiv_mode_latch
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] pins_i,
    input  logic [2:0] hi_i,
    output mode_word_t mode_o
);

    mode_word_t mode_q;

    // tracks inputs while reset is high; the last reset edge fixes the word
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.hi   <= hi_i;
            mode_q.pins <= pins_i;
        end
    end

    assign mode_o = mode_q;

    assert_mode_capture_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_o == {$past(hi_i), $past(pins_i)}));

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_o));

endmodule

// File: rtl/clkdiv_baud_sel.sv
module clkdiv_baud_sel
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_i,
    input  logic [1:0] data_i,
    output baud_sel_e sel_o,
    output logic      restart_o
);

    baud_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= BAUD_DIV16;
        else if (wr_i) sel_q <= baud_sel_e'(data_i);
    end

    assign sel_o     = sel_q;
    assign restart_o = wr_i & ~rst;

    assert_sel_default_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_o == BAUD_DIV16));

    assert_sel_load_R7: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (sel_o == baud_sel_e'($past(data_i))));

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart_i,
    input  logic [W-1:0] last_i,
    output logic         pulse_o
);

    logic [W-1:0] cnt_q;
    logic         pulse_q;
    logic         at_end;

    assign at_end = (cnt_q == last_i);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (at_end) begin
            cnt_q   <= '0;
            pulse_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            pulse_q <= 1'b0;
        end
    end

    assign pulse_o = pulse_q;

    assert_rst_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pulse_o && cnt_q == '0));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_i);

    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !pulse_o);

endmodule

// File: rtl/clkdiv_ctrl_top.sv
module clkdiv_ctrl_top
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       por_rst,
    input  logic [2:0] mode_pins,
    input  logic [2:0] cfg_hi,
    input  logic       bsel_wr,
    input  logic [1:0] bsel_data,
    output logic [5:0] mode_word,
    output logic       scc_en,
    output logic       cpm_en,
    output logic       baud_en
);

    mode_word_t          mode_w;
    baud_sel_e           sel_w;
    logic                restart_w;
    logic [N_FIXED-1:0]  fixed_en;
    clk_en_t             en_w;

    clkdiv_mode_latch u_mode (
        .clk    (clk),
        .rst    (por_rst),
        .pins_i (mode_pins),
        .hi_i   (cfg_hi),
        .mode_o (mode_w)
    );

    clkdiv_baud_sel u_bsel (
        .clk       (clk),
        .rst       (por_rst),
        .wr_i      (bsel_wr),
        .data_i    (bsel_data),
        .sel_o     (sel_w),
        .restart_o (restart_w)
    );

    // fixed-factor domains: index 0 = comms processor, 1 = serial controller
    for (genvar g = 0; g < N_FIXED; g++) begin : g_fixed
        localparam cnt_t LAST = cnt_t'(fixed_div(g) - 1);
        clkdiv_counter #(.W(CNT_W)) u_div (
            .clk       (clk),
            .rst       (por_rst),
            .restart_i (1'b0),
            .last_i    (LAST),
            .pulse_o   (fixed_en[g])
        );
    end

    clkdiv_counter #(.W(CNT_W)) u_baud (
        .clk       (clk),
        .rst       (por_rst),
        .restart_i (restart_w),
        .last_i    (baud_last(sel_w)),
        .pulse_o   (en_w.baud)
    );

    assign en_w.cpm = fixed_en[0];
    assign en_w.scc = fixed_en[1];

    assign mode_word = mode_w;
    assign scc_en    = en_w.scc;
    assign cpm_en    = en_w.cpm;
    assign baud_en   = en_w.baud;

    assert_scc_in_cpm_R9: assert property (@(posedge clk) disable iff (por_rst)
        scc_en |-> cpm_en);

endmodule

// File: tb/clkdiv_ctrl_tb.sv
module clkdiv_ctrl_top_tb_top;

    typedef struct {
        int         cyc;
        bit         scc;
        bit         cpm;
        bit         baud;
        bit         mchk;
        logic [5:0] mode;
        string      breq;
        string      mreq;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       por_rst = 1'b1;
    logic [2:0] mode_pins = '0;
    logic [2:0] cfg_hi = '0;
    logic       bsel_wr = 1'b0;
    logic [1:0] bsel_data = '0;
    logic [5:0] mode_word;
    logic       scc_en, cpm_en, baud_en;

    int errors = 0;
    int checks = 0;
    int cyc_cnt = 0;

    exp_item_t exp_q[$];
    exp_item_t cur;

    // phase state used by the driver to predict outputs
    bit         in_rst = 1'b1;
    int         rel_c = 0;
    int         baud_b = 0;
    int         baud_p = 16;
    logic [5:0] cap_mode = '0;
    string      baud_req = "R6";

    clkdiv_ctrl_top dut_i (
        .clk       (clk),
        .por_rst   (por_rst),
        .mode_pins (mode_pins),
        .cfg_hi    (cfg_hi),
        .bsel_wr   (bsel_wr),
        .bsel_data (bsel_data),
        .mode_word (mode_word),
        .scc_en    (scc_en),
        .cpm_en    (cpm_en),
        .baud_en   (baud_en)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d",
                     req, what, cyc_cnt, act, exp);
        end
    endtask

    // monitor: pop expected items for the edge just completed
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc == cyc_cnt) begin
            cur = exp_q.pop_front();
            chk(in_rst ? "R3" : "R4", "cpm_en", int'(cpm_en), int'(cur.cpm));
            chk(in_rst ? "R3" : "R5 R9", "scc_en", int'(scc_en), int'(cur.scc));
            chk(cur.breq, "baud_en", int'(baud_en), int'(cur.baud));
            if (cur.mchk) chk(cur.mreq, "mode_word", int'(mode_word), int'(cur.mode));
        end
    end

    function automatic bit hit(int c, int base, int per);
        return (c > base) && (((c - base) % per) == 0);
    endfunction

    task automatic push_for(int c);
        exp_item_t it;
        it.cyc  = c;
        it.mchk = !in_rst;
        it.mode = cap_mode;
        it.mreq = (c == rel_c + 1) ? "R1" : "R2";
        it.breq = in_rst ? "R3" : baud_req;
        if (in_rst) begin
            it.cpm = 0; it.scc = 0; it.baud = 0;
        end else begin
            it.cpm  = hit(c, rel_c, 2);
            it.scc  = hit(c, rel_c, 4);
            it.baud = hit(c, baud_b, baud_p);
        end
        exp_q.push_back(it);
    endtask

    // run n cycles, scrambling the mode inputs each cycle
    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            mode_pins = 3'($urandom);
            cfg_hi    = 3'($urandom);
            push_for(cyc_cnt + 1);
            @(negedge clk);
        end
    endtask

    // hold reset for n edges (n >= 3); one select write lands inside the window
    task automatic do_reset(int n);
        por_rst = 1'b1;
        @(negedge clk);
        in_rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            mode_pins = 3'($urandom);
            cfg_hi    = 3'($urandom);
            bsel_wr   = (i == 1);
            bsel_data = 2'b00;
            push_for(cyc_cnt + 1);
            @(negedge clk);
        end
        bsel_wr  = 1'b0;
        cap_mode = {cfg_hi, mode_pins};
        por_rst  = 1'b0;
        in_rst   = 1'b0;
        rel_c    = cyc_cnt;
        baud_b   = cyc_cnt;
        baud_p   = 16;
        baud_req = "R6";
    endtask

    task automatic do_write(logic [1:0] code, int per, string req);
        bsel_wr   = 1'b1;
        bsel_data = code;
        baud_b    = cyc_cnt + 1;
        baud_p    = per;
        baud_req  = req;
        push_for(cyc_cnt + 1);
        @(negedge clk);
        bsel_wr = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(5);
        run(40);
        do_write(2'b00, 4, "R7");
        run(13);
        do_write(2'b00, 4, "R8");
        run(2);
        do_write(2'b10, 64, "R7");
        run(140);
        do_write(2'b11, 256, "R7");
        run(530);
        do_write(2'b01, 16, "R8");
        run(7);
        do_write(2'b10, 64, "R8");
        run(70);
        do_reset(4);
        run(40);
        do_reset(3);
        run(20);
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule